// File: doc/BRIEF.md
# DMA Channel Request Qualifier and Arbiter

This block sits between the per-channel request lines of a DMA controller and its transfer sequencer. Each channel can ask for service with an external single request line, an external burst request line, or a software pulse. The block gates each request with the channel's enable, mask and burst-only control bits. It then picks one winner with a two-level fixed priority and issues a one-cycle grant to the sequencer. The grant carries the channel index, whether it is a single or a burst grant, and the beat count.

After the sequencer reports that a channel has been serviced, the block routes that channel's completion. The route is either a per-peripheral done pulse or a shared combined-done pulse, chosen by the channel's done-mask bit. The channel's active indication reaches the peripheral under the same rule. A wait-on-request bit keeps a serviced channel active until its request lines fall. This serves requesters that run slower than the controller or sit in another clock domain.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel whose enable bit is 0 is never granted, whatever its single, burst or software requests are.
- R2: A channel whose mask bit is 1 gets no grant from its external single or burst lines.
- R3: A channel whose burst-only bit is 1 ignores its single line but is still granted on its burst line. With the bit at 0, a single line alone produces a single grant (`grant_burst` = 0).
- R4: A software pulse on bit c is remembered and then produces a burst grant for channel c. Pulse bits at index NUM_CH or above produce no grant.
- R5: `grant_beats` equals 2^`arb_rate` for a burst grant and 1 for a single grant.
- R6: When any eligible channel has its priority bit set to 1, the winner is taken only from those high-priority channels.
- R7: Among eligible channels of the same priority level, the lowest-numbered channel wins.
- R8: A grant is issued only when `glob_en` and `seq_idle` were both 1 at the deciding clock edge. `grant_valid` rises one cycle after an eligible request meets these conditions.
- R9: A granted channel is active and is not granted again until it leaves the active state. When it is serviced with its wait bit at 0, it leaves the active state at once, even if its request line is still high. With the wait bit at 1 it stays active until both of its request lines are low.
- R10: With done-mask bit 0, a service completion pulses `periph_done[c]` and the channel's active state shows on `periph_active[c]`. With the bit at 1, both peripheral outputs stay low and `comb_done` pulses instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glob_en | input | 1 | Global controller enable |
| seq_idle | input | 1 | Sequencer is ready to accept a grant |
| arb_rate | input | RATE_W | Arbitration-rate exponent for burst grants |
| chan_en | input | NUM_CH | Per-channel enable |
| req_mask | input | NUM_CH | Per-channel external request mask |
| burst_only | input | NUM_CH | Per-channel single-request suppression |
| hi_prio | input | NUM_CH | Per-channel high-priority select |
| wait_req | input | NUM_CH | Per-channel wait-on-request hold |
| done_mask | input | NUM_CH | Per-channel done routing select |
| sreq | input | NUM_CH | External single request lines |
| breq | input | NUM_CH | External burst request lines |
| sw_req | input | SW_W | Software request pulses |
| svc_done | input | 1 | Sequencer finished servicing a channel |
| done_ch | input | IDX_W | Index of the serviced channel |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_ch | output | IDX_W | Granted channel index |
| grant_burst | output | 1 | 1 for a burst grant, 0 for a single grant |
| grant_beats | output | 2^RATE_W | Transfers to perform for this grant |
| periph_active | output | NUM_CH | Active state routed to each peripheral |
| periph_done | output | NUM_CH | Done pulse routed to each peripheral |
| comb_done | output | 1 | Combined done pulse |

## Verification
A request applied before a clock edge shows on the grant outputs after that edge, one cycle later. A software pulse needs one more cycle, because it is latched first. A completion reported with `svc_done` shows on `periph_done`/`comb_done` after the next edge. `periph_active` changes in the same cycle as the grant or the release. The bench drives inputs on the falling edge and reads every result at the following falling edge. It drops `seq_idle` as soon as a grant is seen, as a sequencer would. Blocked cases are checked by watching the grant outputs over the cycles in which a grant would otherwise have appeared.

// File: rtl/dma_arb_pkg.sv
// Package: shared helpers for the DMA request arbiter.
// Assumes: channel counts of at least two.
package dma_arb_pkg;
    // Transfer kind carried with a grant.
    typedef enum logic {
        XFER_SINGLE = 1'b0,
        XFER_BURST  = 1'b1
    } xfer_kind_e;
endpackage

// File: rtl/dma_req_qual.sv
// Module: dma_req_qual
// Gates raw request lines with the enable, mask and burst-only vectors.
// Assumes: sw_pend and act come from dma_chan_track; purely combinational.
module dma_req_qual #(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] req_mask,
    input  logic [NUM_CH-1:0] burst_only,
    input  logic [NUM_CH-1:0] sreq,
    input  logic [NUM_CH-1:0] breq,
    input  logic [NUM_CH-1:0] sw_pend,
    input  logic [NUM_CH-1:0] act,
    output logic [NUM_CH-1:0] elig,
    output logic [NUM_CH-1:0] burst_ok
);
    logic [NUM_CH-1:0] ext_on;
    logic [NUM_CH-1:0] single_ok;

    // Qualify single, burst and software requests per channel.
    always_comb begin
        ext_on    = chan_en & ~req_mask;
        single_ok = sreq & ext_on & ~burst_only;
        burst_ok  = (breq & ext_on) | (sw_pend & chan_en);
        elig      = (single_ok | burst_ok) & ~act;
    end
endmodule

// File: rtl/dma_prio_pick.sv
// Module: dma_prio_pick
// Finds the lowest-numbered set bit of a request vector.
// Assumes: IDX_W wide enough to hold NUM_CH-1.
module dma_prio_pick #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic [NUM_CH-1:0] req,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Scan downwards so the lowest index is the last to be taken.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dma_chan_track.sv
// Module: dma_chan_track
// Holds per-channel software-pending, active and wait-hold state.
// Assumes: one grant and one completion at most per cycle.
module dma_chan_track #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sw_hit,
    input  logic              grant_fire,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              svc_done,
    input  logic [IDX_W-1:0]  done_ch,
    input  logic [NUM_CH-1:0] wait_req,
    input  logic [NUM_CH-1:0] line_up,
    output logic [NUM_CH-1:0] sw_pend,
    output logic [NUM_CH-1:0] act
);
    logic [NUM_CH-1:0] hold;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic won;
        logic fin;
        assign won = grant_fire && (win_idx == IDX_W'(c));
        assign fin = svc_done && (done_ch == IDX_W'(c));

        // Latch software pulses until the channel is granted.
        always_ff @(posedge clk) begin
            if (!rst_n)         sw_pend[c] <= 1'b0;
            else if (sw_hit[c]) sw_pend[c] <= 1'b1;
            else if (won)       sw_pend[c] <= 1'b0;
        end

        // Track active state and the wait-on-request hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act[c]  <= 1'b0;
                hold[c] <= 1'b0;
            end else if (won) begin
                act[c]  <= 1'b1;
                hold[c] <= 1'b0;
            end else if (fin) begin
                if (wait_req[c] && line_up[c]) hold[c] <= 1'b1;
                else                           act[c]  <= 1'b0;
            end else if (hold[c] && !line_up[c]) begin
                act[c]  <= 1'b0;
                hold[c] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_done_route.sv
// Module: dma_done_route
// Steers completion and active state to peripherals or the combined line.
// Assumes: done_ch below NUM_CH whenever svc_done is high.
module dma_done_route #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_done,
    input  logic [IDX_W-1:0]  done_ch,
    input  logic [NUM_CH-1:0] done_mask,
    input  logic [NUM_CH-1:0] act,
    output logic [NUM_CH-1:0] periph_active,
    output logic [NUM_CH-1:0] periph_done,
    output logic              comb_done
);
    logic [NUM_CH-1:0] hit;

    // Decode the completing channel.
    always_comb begin
        hit = '0;
        if (svc_done) hit[done_ch] = 1'b1;
    end

    // Register the routed done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            periph_done <= '0;
            comb_done   <= 1'b0;
        end else begin
            periph_done <= hit & ~done_mask;
            comb_done   <= |(hit & done_mask);
        end
    end

    // Active state reaches only unmasked peripherals.
    assign periph_active = act & ~done_mask;
endmodule

// File: rtl/dma_req_arbiter.sv
// Module: dma_req_arbiter (top)
// Qualifies channel requests, grants one by two-level fixed priority,
// and routes completion indications.
// Assumes: sequencer drops seq_idle the cycle after a grant appears.
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NUM_CH  = 8,
    parameter  int SW_W    = 8,
    parameter  int RATE_W  = 4,
    localparam int IDX_W   = $clog2(NUM_CH),
    localparam int BEATS_W = 2 ** RATE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glob_en,
    input  logic               seq_idle,
    input  logic [RATE_W-1:0]  arb_rate,
    input  logic [NUM_CH-1:0]  chan_en,
    input  logic [NUM_CH-1:0]  req_mask,
    input  logic [NUM_CH-1:0]  burst_only,
    input  logic [NUM_CH-1:0]  hi_prio,
    input  logic [NUM_CH-1:0]  wait_req,
    input  logic [NUM_CH-1:0]  done_mask,
    input  logic [NUM_CH-1:0]  sreq,
    input  logic [NUM_CH-1:0]  breq,
    input  logic [SW_W-1:0]    sw_req,
    input  logic               svc_done,
    input  logic [IDX_W-1:0]   done_ch,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_ch,
    output logic               grant_burst,
    output logic [BEATS_W-1:0] grant_beats,
    output logic [NUM_CH-1:0]  periph_active,
    output logic [NUM_CH-1:0]  periph_done,
    output logic               comb_done
);
    logic [NUM_CH-1:0] sw_pend, act, elig, burst_ok;
    logic              hi_found, any_found, grant_fire;
    logic [IDX_W-1:0]  hi_idx, any_idx, win_idx;
    xfer_kind_e        win_kind;

    dma_req_qual #(.NUM_CH(NUM_CH)) u_qual (
        .chan_en(chan_en), .req_mask(req_mask), .burst_only(burst_only),
        .sreq(sreq), .breq(breq), .sw_pend(sw_pend), .act(act),
        .elig(elig), .burst_ok(burst_ok)
    );

    dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick_hi (
        .req(elig & hi_prio), .found(hi_found), .idx(hi_idx)
    );

    dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick_any (
        .req(elig), .found(any_found), .idx(any_idx)
    );

    // Choose the winner and decide whether a grant fires this cycle.
    always_comb begin
        win_idx    = hi_found ? hi_idx : any_idx;
        win_kind   = burst_ok[win_idx] ? XFER_BURST : XFER_SINGLE;
        grant_fire = glob_en && seq_idle && any_found;
    end

    // Register the grant presented to the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_ch    <= '0;
            grant_burst <= 1'b0;
            grant_beats <= '0;
        end else begin
            grant_valid <= grant_fire;
            if (grant_fire) begin
                grant_ch    <= win_idx;
                grant_burst <= (win_kind == XFER_BURST);
                grant_beats <= (win_kind == XFER_BURST)
                             ? (BEATS_W'(1) << arb_rate) : BEATS_W'(1);
            end
        end
    end

    dma_chan_track #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .sw_hit(sw_req[NUM_CH-1:0]),
        .grant_fire(grant_fire), .win_idx(win_idx),
        .svc_done(svc_done), .done_ch(done_ch), .wait_req(wait_req),
        .line_up(sreq | breq), .sw_pend(sw_pend), .act(act)
    );

    dma_done_route #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_route (
        .clk(clk), .rst_n(rst_n), .svc_done(svc_done), .done_ch(done_ch),
        .done_mask(done_mask), .act(act), .periph_active(periph_active),
        .periph_done(periph_done), .comb_done(comb_done)
    );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
// Module: dma_req_arbiter_chk
// Port-level properties of the arbiter, bound to every instance.
// Assumes: same parameters as the bound instance.
module dma_req_arbiter_chk #(
    parameter int NUM_CH  = 8,
    parameter int IDX_W   = 3,
    parameter int BEATS_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               glob_en,
    input logic               seq_idle,
    input logic [NUM_CH-1:0]  chan_en,
    input logic               svc_done,
    input logic               grant_valid,
    input logic [IDX_W-1:0]   grant_ch,
    input logic               grant_burst,
    input logic [BEATS_W-1:0] grant_beats,
    input logic [NUM_CH-1:0]  periph_done,
    input logic               comb_done
);
    logic [NUM_CH-1:0] en_q;

    // Remember the enables seen at the deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= chan_en;
    end

    p_enabled_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> en_q[grant_ch]);

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(glob_en && seq_idle));

    p_single_beats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_burst) |-> (grant_beats == BEATS_W'(1)));

    p_burst_beats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_burst) |-> ($countones(grant_beats) == 1));

    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_done != '0) || comb_done) |-> $past(svc_done));

    p_done_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({periph_done, comb_done}));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
    .NUM_CH(NUM_CH), .IDX_W(IDX_W), .BEATS_W(BEATS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .seq_idle(seq_idle),
    .chan_en(chan_en), .svc_done(svc_done), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .grant_burst(grant_burst), .grant_beats(grant_beats),
    .periph_done(periph_done), .comb_done(comb_done)
);

// File: tb/dma_req_arbiter_test.sv
// Directed bench for dma_req_arbiter: six channels, eight software bits.
module dma_req_arbiter_test;
    localparam int PERIOD  = 10;
    localparam int NCH     = 6;
    localparam int SWB     = 8;
    localparam int RW      = 4;
    localparam int IW      = 3;
    localparam int BW      = 16;

    logic clk = 1'b0;
    logic rst_n, glob_en, seq_idle, svc_done;
    logic [RW-1:0]  arb_rate;
    logic [NCH-1:0] chan_en, req_mask, burst_only, hi_prio, wait_req, done_mask, sreq, breq;
    logic [SWB-1:0] sw_req;
    logic [IW-1:0]  done_ch;
    logic           grant_valid, grant_burst, comb_done;
    logic [IW-1:0]  grant_ch;
    logic [BW-1:0]  grant_beats;
    logic [NCH-1:0] periph_active, periph_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_req_arbiter #(.NUM_CH(NCH), .SW_W(SWB), .RATE_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .seq_idle(seq_idle),
        .arb_rate(arb_rate), .chan_en(chan_en), .req_mask(req_mask),
        .burst_only(burst_only), .hi_prio(hi_prio), .wait_req(wait_req),
        .done_mask(done_mask), .sreq(sreq), .breq(breq), .sw_req(sw_req),
        .svc_done(svc_done), .done_ch(done_ch), .grant_valid(grant_valid),
        .grant_ch(grant_ch), .grant_burst(grant_burst), .grant_beats(grant_beats),
        .periph_active(periph_active), .periph_done(periph_done),
        .comb_done(comb_done)
    );

    task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    // Reset with every control at its idle value.
    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0; glob_en = 1'b1; seq_idle = 1'b1; svc_done = 1'b0;
        arb_rate = '0; chan_en = '1; req_mask = '0; burst_only = '0;
        hi_prio = '0; wait_req = '0; done_mask = '0; sreq = '0; breq = '0;
        sw_req = '0; done_ch = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait one cycle and compare the grant outputs.
    task automatic expect_grant(input logic v, input int ch, input logic b,
                                input int beats, input string tag);
        @(negedge clk);
        chk(grant_valid == v, {tag, " valid"}, int'(grant_valid), int'(v));
        if (v) begin
            chk(grant_ch == IW'(ch), {tag, " channel"}, int'(grant_ch), ch);
            chk(grant_burst == b, {tag, " kind"}, int'(grant_burst), int'(b));
            chk(grant_beats == BW'(beats), {tag, " beats"}, int'(grant_beats), beats);
            seq_idle = 1'b0;
        end
    endtask

    // Report one completion; done outputs are readable on return.
    task automatic serve(input int ch);
        svc_done = 1'b1; done_ch = IW'(ch);
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic t_reset();
        restart();
        @(negedge clk);
        chk(grant_valid == 1'b0, "R8 reset grant", int'(grant_valid), 0);
        chk(periph_active == '0, "R10 reset active", int'(periph_active), 0);
        chk(periph_done == '0 && !comb_done, "R10 reset done", int'(periph_done), 0);
    endtask

    task automatic t_single_nowait();
        restart();
        arb_rate = 4'd3; sreq[3] = 1'b1;
        expect_grant(1'b1, 3, 1'b0, 1, "R5 single grant");
        chk(periph_active == 6'b001000, "R10 active shown", int'(periph_active), 8);
        serve(3);
        chk(periph_done == 6'b001000, "R10 periph done", int'(periph_done), 8);
        chk(comb_done == 1'b0, "R10 no combined", int'(comb_done), 0);
        chk(periph_active == '0, "R9 release without wait", int'(periph_active), 0);
        seq_idle = 1'b1;
        expect_grant(1'b1, 3, 1'b0, 1, "R9 regrant");
    endtask

    task automatic t_disabled();
        restart();
        chan_en = 6'b111011; sreq[2] = 1'b1; breq[2] = 1'b1; sw_req[2] = 1'b1;
        @(negedge clk); sw_req = '0;
        expect_grant(1'b0, 0, 1'b0, 0, "R1 disabled blocked");
        expect_grant(1'b0, 0, 1'b0, 0, "R1 disabled still blocked");
        arb_rate = 4'd1; chan_en = '1;
        expect_grant(1'b1, 2, 1'b1, 2, "R1 enabled grant");
    endtask

    task automatic t_mask();
        restart();
        arb_rate = 4'd2; req_mask[1] = 1'b1; sreq[1] = 1'b1; breq[1] = 1'b1;
        expect_grant(1'b0, 0, 1'b0, 0, "R2 masked");
        expect_grant(1'b0, 0, 1'b0, 0, "R2 masked again");
        req_mask = '0;
        expect_grant(1'b1, 1, 1'b1, 4, "R2 unmasked burst");
    endtask

    task automatic t_burst_only();
        restart();
        arb_rate = 4'd5; burst_only[4] = 1'b1; sreq[4] = 1'b1;
        expect_grant(1'b0, 0, 1'b0, 0, "R3 single suppressed");
        breq[4] = 1'b1;
        expect_grant(1'b1, 4, 1'b1, 32, "R3 burst served");
    endtask

    task automatic t_software();
        restart();
        arb_rate = 4'd3; sw_req[7] = 1'b1;
        @(negedge clk); sw_req = '0;
        expect_grant(1'b0, 0, 1'b0, 0, "R4 unimplemented bit");
        expect_grant(1'b0, 0, 1'b0, 0, "R4 unimplemented bit later");
        sw_req[5] = 1'b1;
        @(negedge clk); sw_req = '0;
        expect_grant(1'b1, 5, 1'b1, 8, "R4 software burst");
        serve(5); seq_idle = 1'b1;
        expect_grant(1'b0, 0, 1'b0, 0, "R4 pending cleared");
    endtask

    task automatic t_priority();
        restart();
        hi_prio[5] = 1'b1; sreq = 6'b110100;
        expect_grant(1'b1, 5, 1'b0, 1, "R6 high first");
        sreq[5] = 1'b0; serve(5); seq_idle = 1'b1;
        expect_grant(1'b1, 2, 1'b0, 1, "R7 lowest index");
        sreq[2] = 1'b0; serve(2); seq_idle = 1'b1;
        expect_grant(1'b1, 4, 1'b0, 1, "R7 next lowest");
    endtask

    task automatic t_gate();
        restart();
        glob_en = 1'b0; sreq[1] = 1'b1;
        expect_grant(1'b0, 0, 1'b0, 0, "R8 global off");
        glob_en = 1'b1; seq_idle = 1'b0;
        expect_grant(1'b0, 0, 1'b0, 0, "R8 sequencer busy");
        seq_idle = 1'b1;
        expect_grant(1'b1, 1, 1'b0, 1, "R8 grant when ready");
    endtask

    task automatic t_wait();
        restart();
        arb_rate = 4'd2; wait_req[0] = 1'b1; breq[0] = 1'b1;
        expect_grant(1'b1, 0, 1'b1, 4, "R9 wait grant");
        serve(0);
        chk(periph_active[0] == 1'b1, "R9 held active", int'(periph_active), 1);
        seq_idle = 1'b1;
        expect_grant(1'b0, 0, 1'b0, 0, "R9 no regrant while held");
        breq[0] = 1'b0;
        @(negedge clk);
        chk(periph_active == '0, "R9 released on drop", int'(periph_active), 0);
        breq[0] = 1'b1;
        expect_grant(1'b1, 0, 1'b1, 4, "R9 grant after release");
    endtask

    task automatic t_done_mask();
        restart();
        done_mask[5] = 1'b1; sreq[5] = 1'b1;
        expect_grant(1'b1, 5, 1'b0, 1, "R10 masked grant");
        chk(periph_active == '0, "R10 active blocked", int'(periph_active), 0);
        sreq[5] = 1'b0; serve(5);
        chk(periph_done == '0, "R10 peripheral blocked", int'(periph_done), 0);
        chk(comb_done == 1'b1, "R10 combined pulse", int'(comb_done), 1);
    endtask

    initial begin
        t_reset();
        t_single_nowait();
        t_disabled();
        t_mask();
        t_burst_only();
        t_software();
        t_priority();
        t_gate();
        t_wait();
        t_done_mask();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule